// File: doc/BRIEF.md
# Program Memory Lock Protection Unit

This block guards on-chip program memory against readout and tampering. It sits between the CPU instruction fetch path, the table-read (code-as-data) path, the external programming and verify port, and the program store itself. Three lock bits are held in non-volatile storage, which is modelled here as a register filled while reset is held. They select one of four protection levels, and each level adds to the one below it. The levels take away, in turn, table reads made by external code into internal code, programming, verify readout, and finally execution from external memory.

The unit also holds the external-access strap pin, which picks internal or external code space. When the first lock bit is programmed, the unit latches the pin's level during reset and reports that latched copy in place of the live pin. A flag goes high whenever the live pin and the latched copy disagree. A denied read returns a fixed all-ones byte. A denied program request produces a single error pulse one cycle later.

Top module: `code_guard`

## Requirements
- R1: `lock_nv_i` carries the lock bits, with bit 0 as the first bit, bit 1 as the second and bit 2 as the third, and 1 meaning programmed. The bits are captured on every rising clock edge while `rst_n` is low. `level_o` shows the level: 0 when bit 0 is clear, 1 for bit 0 only, 2 for bits 0 and 1, and 3 for all three. `level_o` does not change while `rst_n` stays high.
- R2: While `rst_n` is low, every grant output and `prg_err_o` are low, whatever the requests.
- R3: `fetch_grant_o` equals `fetch_req_i`, except at level 3 when `fetch_ext_i` is 1 (fetch from external memory). That fetch is refused.
- R4: A table read is refused when the level is 1 or above, `tbl_src_ext_i` is 1 (the issuing code runs from external memory) and `tbl_tgt_int_i` is 1 (the target is internal code). In every other case `tbl_grant_o` equals `tbl_req_i`.
- R5: `tbl_rdata_o` equals `code_rdata_i` when `tbl_grant_o` is 1 and equals 8'hFF otherwise.
- R6: `vfy_grant_o` equals `vfy_req_i` at levels 0 and 1 and is 0 at levels 2 and 3. `vfy_rdata_o` equals `code_rdata_i` when granted and 8'hFF otherwise.
- R7: `prg_grant_o` equals `prg_req_i` at level 0 and is 0 at every other level.
- R8: A program request whose first cycle falls at level 1 or above drives `prg_err_o` high in the next cycle, for exactly one cycle. This holds even when the request stays high for several cycles.
- R9: At level 1 or above, `ext_latch_o` shows the value `ext_pin_i` had at the last rising edge with `rst_n` low. At level 0 it follows `ext_pin_i` directly.
- R10: `ext_mismatch_o` is 1 exactly when the level is 1 or above and `ext_latch_o` differs from the live `ext_pin_i`.
- R11: Lock patterns that are not among the four listed take the strictest level whose bits are all programmed. 3'b010, 3'b100 and 3'b110 give level 0, and 3'b101 gives level 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset; lock bits and strap pin are captured while low |
| lock_nv_i | input | 3 | Non-volatile lock bits, 1 = programmed |
| ext_pin_i | input | 1 | Live external-access strap pin |
| code_rdata_i | input | 8 | Byte read from the program store |
| fetch_req_i | input | 1 | Instruction fetch request |
| fetch_ext_i | input | 1 | Fetch targets external memory |
| fetch_grant_o | output | 1 | Fetch allowed |
| tbl_req_i | input | 1 | Table read request |
| tbl_src_ext_i | input | 1 | Issuing code executes from external memory |
| tbl_tgt_int_i | input | 1 | Table read targets internal code |
| tbl_grant_o | output | 1 | Table read allowed |
| tbl_rdata_o | output | 8 | Table read data, all ones when refused |
| vfy_req_i | input | 1 | Verify read request |
| vfy_grant_o | output | 1 | Verify allowed |
| vfy_rdata_o | output | 8 | Verify data, all ones when refused |
| prg_req_i | input | 1 | Program request |
| prg_grant_o | output | 1 | Program allowed |
| prg_err_o | output | 1 | One-cycle pulse after a refused program request |
| ext_latch_o | output | 1 | Effective strap value (latched or live) |
| ext_mismatch_o | output | 1 | Latched strap differs from live pin |
| level_o | output | 2 | Active protection level 0..3 |

## Verification
The assertions assume that the lock bits and the strap pin are settled before the last clock edge of reset, and that the lock value does not need to change outside reset. The bench meets this by changing `lock_nv_i` only while `rst_n` is low, and by releasing reset on a falling edge. The per-cycle checks of error pulses assume that requests change only between clock edges. The bench therefore drives every input on the falling edge and samples just after it. All eight lock patterns are combined with both strap levels, and every combination of the seven request tags is swept under each of them.

// File: rtl/code_guard_pkg.sv
package code_guard_pkg;

   localparam int LOCK_BITS = 3;
   localparam int LVL_W     = 2;

   typedef enum logic [LVL_W-1:0] {
      LVL_OPEN = 2'd0,
      LVL_TBL  = 2'd1,
      LVL_VFY  = 2'd2,
      LVL_EXE  = 2'd3
   } guard_lvl_e;

endpackage

// File: rtl/code_guard_lock.sv
module code_guard_lock
   import code_guard_pkg::*;
(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LOCK_BITS-1:0] lock_nv_i,
   input  logic                 ext_pin_i,
   output guard_lvl_e           level_o,
   output logic                 ext_eff_o,
   output logic                 ext_mismatch_o
);

   if (LOCK_BITS != 3) begin : g_bad_lock
      $error("code_guard_lock: level decode assumes three lock bits");
   end

   logic [LOCK_BITS-1:0] lock_q;
   logic                 strap_q;
   logic [LOCK_BITS-1:0] run;

   // non-volatile image and strap are refreshed only while reset is held
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lock_q  <= lock_nv_i;
         strap_q <= ext_pin_i;
      end
   end

   // a level counts only when every lower lock bit is also programmed
   assign run[0] = lock_q[0];
   for (genvar i = 1; i < LOCK_BITS; i++) begin : g_run
      assign run[i] = run[i-1] & lock_q[i];
   end

   assign level_o        = guard_lvl_e'(LVL_W'($countones(run)));
   assign ext_eff_o      = lock_q[0] ? strap_q : ext_pin_i;
   assign ext_mismatch_o = lock_q[0] & (strap_q ^ ext_pin_i);

   assert_level_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $past(rst_n) |-> $stable(level_o));

   assert_strap_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && level_o != LVL_OPEN) |-> $stable(ext_eff_o));

endmodule

// File: rtl/code_guard_rgate.sv
module code_guard_rgate #(
   parameter int                DATA_W    = 8,
   parameter logic [DATA_W-1:0] DENY_FILL = '1
) (
   input  logic              req_i,
   input  logic              block_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              grant_o,
   output logic [DATA_W-1:0] data_o
);

   assign grant_o = req_i & ~block_i;
   assign data_o  = grant_o ? data_i : DENY_FILL;

endmodule

// File: rtl/code_guard_prog.sv
module code_guard_prog #(
   parameter bit ERR_PER_REQ = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_i,
   input  logic block_i,
   output logic grant_o,
   output logic err_o
);

   logic start;
   logic err_q;

   if (ERR_PER_REQ) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk) begin
         if (!rst_n) prev_q <= 1'b0;
         else        prev_q <= req_i;
      end
      assign start = req_i & ~prev_q;

      assert_err_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
         err_o |=> !err_o);
   end else begin : g_level
      assign start = req_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= start & block_i;
   end

   assign grant_o = req_i & ~block_i & rst_n;
   assign err_o   = err_q;

   assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> $past(req_i && block_i));

endmodule

// File: rtl/code_guard.sv
module code_guard
   import code_guard_pkg::*;
#(
   parameter int  DATA_W      = 8,
   parameter bit  ERR_PER_REQ = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LOCK_BITS-1:0] lock_nv_i,
   input  logic                 ext_pin_i,
   input  logic [DATA_W-1:0]    code_rdata_i,
   input  logic                 fetch_req_i,
   input  logic                 fetch_ext_i,
   output logic                 fetch_grant_o,
   input  logic                 tbl_req_i,
   input  logic                 tbl_src_ext_i,
   input  logic                 tbl_tgt_int_i,
   output logic                 tbl_grant_o,
   output logic [DATA_W-1:0]    tbl_rdata_o,
   input  logic                 vfy_req_i,
   output logic                 vfy_grant_o,
   output logic [DATA_W-1:0]    vfy_rdata_o,
   input  logic                 prg_req_i,
   output logic                 prg_grant_o,
   output logic                 prg_err_o,
   output logic                 ext_latch_o,
   output logic                 ext_mismatch_o,
   output logic [LVL_W-1:0]     level_o
);

   localparam int                N_RD      = 2;
   localparam int                RD_TBL    = 0;
   localparam int                RD_VFY    = 1;
   localparam logic [DATA_W-1:0] DENY_FILL = '1;

   if (DATA_W < 1 || DATA_W > 64) begin : g_bad_width
      $error("code_guard: DATA_W out of range");
   end

   guard_lvl_e        lvl;
   logic [N_RD-1:0]   rd_req;
   logic [N_RD-1:0]   rd_blk;
   logic [N_RD-1:0]   rd_gnt;
   logic [DATA_W-1:0] rd_dat [N_RD];
   logic              tbl_hit;

   code_guard_lock u_lock (
      .clk            (clk),
      .rst_n          (rst_n),
      .lock_nv_i      (lock_nv_i),
      .ext_pin_i      (ext_pin_i),
      .level_o        (lvl),
      .ext_eff_o      (ext_latch_o),
      .ext_mismatch_o (ext_mismatch_o)
   );

   assign tbl_hit        = tbl_src_ext_i & tbl_tgt_int_i;
   assign rd_req[RD_TBL] = tbl_req_i & rst_n;
   assign rd_blk[RD_TBL] = (lvl >= LVL_TBL) & tbl_hit;
   assign rd_req[RD_VFY] = vfy_req_i & rst_n;
   assign rd_blk[RD_VFY] = (lvl >= LVL_VFY);

   for (genvar c = 0; c < N_RD; c++) begin : g_rd
      code_guard_rgate #(
         .DATA_W    (DATA_W),
         .DENY_FILL (DENY_FILL)
      ) u_gate (
         .req_i   (rd_req[c]),
         .block_i (rd_blk[c]),
         .data_i  (code_rdata_i),
         .grant_o (rd_gnt[c]),
         .data_o  (rd_dat[c])
      );
   end

   assign tbl_grant_o = rd_gnt[RD_TBL];
   assign tbl_rdata_o = rd_dat[RD_TBL];
   assign vfy_grant_o = rd_gnt[RD_VFY];
   assign vfy_rdata_o = rd_dat[RD_VFY];

   code_guard_prog #(
      .ERR_PER_REQ (ERR_PER_REQ)
   ) u_prog (
      .clk     (clk),
      .rst_n   (rst_n),
      .req_i   (prg_req_i),
      .block_i (lvl != LVL_OPEN),
      .grant_o (prg_grant_o),
      .err_o   (prg_err_o)
   );

   assign fetch_grant_o = fetch_req_i & rst_n & ~((lvl == LVL_EXE) & fetch_ext_i);
   assign level_o       = lvl;

   always_comb begin
      if (!rst_n) begin
         assert_reset_quiet_R2: assert (!fetch_grant_o && !tbl_grant_o &&
                                        !vfy_grant_o && !prg_grant_o);
      end
   end

   assert_exe_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (level_o == LVL_EXE && fetch_ext_i) |-> !fetch_grant_o);

   assert_tbl_fill_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !tbl_grant_o |-> (tbl_rdata_o == DENY_FILL));

   assert_vfy_block_R6: assert property (@(posedge clk) disable iff (!rst_n)
      vfy_grant_o |-> (level_o < LVL_VFY));

   assert_prg_block_R7: assert property (@(posedge clk) disable iff (!rst_n)
      prg_grant_o |-> (level_o == LVL_OPEN));

   assert_mismatch_lvl_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ext_mismatch_o |-> (level_o != LVL_OPEN && ext_latch_o != ext_pin_i));

endmodule

// File: tb/sim_code_guard.sv
module sim_code_guard;

   localparam int CLK_P  = 10;
   localparam int DW     = 8;
   localparam int WDOG   = 150000;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [2:0]    lock_nv = 3'b000;
   logic          ext_pin = 1'b0;
   logic [DW-1:0] mem = '0;
   logic          f_req = 0, f_ext = 0, t_req = 0, t_src = 0, t_tgt = 0, v_req = 0, p_req = 0;
   logic          f_gnt, t_gnt, v_gnt, p_gnt, p_err, ea_l, ea_mm;
   logic [DW-1:0] t_dat, v_dat;
   logic [1:0]    lvl;

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   always #(CLK_P/2) clk = ~clk;

   code_guard u0 (
      .clk(clk), .rst_n(rst_n), .lock_nv_i(lock_nv), .ext_pin_i(ext_pin),
      .code_rdata_i(mem),
      .fetch_req_i(f_req), .fetch_ext_i(f_ext), .fetch_grant_o(f_gnt),
      .tbl_req_i(t_req), .tbl_src_ext_i(t_src), .tbl_tgt_int_i(t_tgt),
      .tbl_grant_o(t_gnt), .tbl_rdata_o(t_dat),
      .vfy_req_i(v_req), .vfy_grant_o(v_gnt), .vfy_rdata_o(v_dat),
      .prg_req_i(p_req), .prg_grant_o(p_gnt), .prg_err_o(p_err),
      .ext_latch_o(ea_l), .ext_mismatch_o(ea_mm), .level_o(lvl)
   );

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s: actual=%0h expected=%0h (lock=%b pin=%b)", req, act, exp, lock_nv, ext_pin);
      end
   endtask

   function automatic int exp_lvl(input logic [2:0] p);
      return p[0] ? (p[1] ? (p[2] ? 3 : 2) : 1) : 0;
   endfunction

   task automatic drop_reqs();
      {f_req, f_ext, t_req, t_src, t_tgt, v_req, p_req} = '0;
   endtask

   task automatic do_reset(input logic [2:0] pat, input logic pin);
      @(negedge clk);
      rst_n = 1'b0;
      lock_nv = pat;
      ext_pin = ~pin;
      {f_req, f_ext, t_req, v_req, p_req} = 5'b11111;
      t_src = 1; t_tgt = 0;
      @(negedge clk);
      #1;
      // R2: grants quiet while reset is held
      chk("R2 fetch", f_gnt, 0);
      chk("R2 tbl", t_gnt, 0);
      chk("R2 vfy", v_gnt, 0);
      chk("R2 prg", p_gnt, 0);
      chk("R2 err", p_err, 0);
      ext_pin = pin;      // value at the final reset edge is the one kept
      drop_reqs();
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      #(CLK_P * WDOG);
      if (!done) begin
         total++; bad++;
         $display("FAIL watchdog: actual=hung expected=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      for (int p = 0; p < 8; p++) begin
         for (int e = 0; e < 2; e++) begin
            int L;
            do_reset(3'(p), 1'(e));
            L = exp_lvl(3'(p));
            #1;
            // R1 / R11: level decode, including unlisted patterns
            if (p == 2 || p == 4 || p == 5 || p == 6) chk("R11 level", lvl, L);
            else                                    chk("R1 level", lvl, L);
            // R9 / R10: latched strap
            chk("R9 latch", ea_l, e);
            chk("R10 mismatch", ea_mm, 0);
            ext_pin = ~1'(e);
            #1;
            chk("R9 latch flip", ea_l, (L != 0) ? e : 1 - e);
            chk("R10 mismatch flip", ea_mm, (L != 0) ? 1 : 0);
            @(negedge clk);
            chk("R1 level hold", lvl, L);
            ext_pin = 1'(e);

            // sweep every request tag combination
            for (int v = 0; v < 128; v++) begin
               int fg, tg, vg, pg;
               logic [DW-1:0] d;
               @(negedge clk);
               {f_req, f_ext, t_req, t_src, t_tgt, v_req, p_req} = 7'(v);
               d   = DW'(v * 37 + p * 11 + e);
               mem = d;
               #1;
               fg = (f_req && !(L == 3 && f_ext)) ? 1 : 0;
               tg = (t_req && !(L >= 1 && t_src && t_tgt)) ? 1 : 0;
               vg = (v_req && L < 2) ? 1 : 0;
               pg = (p_req && L == 0) ? 1 : 0;
               chk("R3 fetch", f_gnt, fg);
               chk("R4 tbl grant", t_gnt, tg);
               chk("R5 tbl data", t_dat, tg ? d : 8'hFF);
               chk("R6 vfy grant", v_gnt, vg);
               chk("R6 vfy data", v_dat, vg ? d : 8'hFF);
               chk("R7 prg grant", p_gnt, pg);
            end

            // R8: held request yields a single pulse
            @(negedge clk);
            drop_reqs();
            @(negedge clk);
            p_req = 1;
            @(negedge clk);
            chk("R8 held first", p_err, (L != 0) ? 1 : 0);
            @(negedge clk);
            chk("R8 held second", p_err, 0);
            p_req = 0;
            @(negedge clk);
            chk("R8 after drop", p_err, 0);
            // R8: single-cycle request
            p_req = 1;
            @(negedge clk);
            p_req = 0;
            chk("R8 strobe", p_err, (L != 0) ? 1 : 0);
            @(negedge clk);
            chk("R8 strobe end", p_err, 0);
         end
      end
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule